// File: doc/BRIEF.md
# Nested priority interrupt controller

This block collects up to twenty level-sensitive interrupt requests and drives two request lines toward a processor: a normal-class line and a fast-class line. Each source has a three-bit priority level (0 is the most urgent, 7 the least) and a separate enable bit for each class. Software uses a plain read/write register bus to program the enables, the priority fields, a shared vector base and the per-class nesting switches.

With nesting switched off, a class simply reports its lowest-numbered pending source, and the fast line has precedence over the normal line. With nesting switched on, the class picks the most urgent pending source. Reading that class's vector register returns the base plus the source index. The read also has a side effect: it records the source's level in an eight-bit in-service register. That level and every less urgent level stay masked until software retires them. Each retire write clears only the most urgent level in service, so the handlers must unwind in strict order.

Top module: `nest_irq_ctrl`

## Requirements
- R1: The control register at byte offset 0x00 keeps bit 0 (normal-class nesting) and bit 1 (fast-class nesting). Both reset to 0, and every other bit reads as 0.
- R2: After reset, both in-service registers (normal at 0x18, fast at 0x1C) read 0, and a vector read (normal at 0x10, fast at 0x14) returns 0.
- R3: With nesting off in a class, that class's line is high whenever any source that is both requesting and enabled for the class is pending. The vector then names the lowest-indexed such source, and the priority fields have no effect.
- R4: While normal-class nesting is off, the normal line stays low whenever the fast line is high.
- R5: A vector word is laid out as follows. Bits 1:0 are 0. Bits 6:2 hold the source index. Bits 22:7 hold the base register (offset 0x0C, low 16 bits). Bits 31:23 are 0. Source 8 therefore appears as 01000 in bits 6:2.
- R6: With nesting on, a vector read while the line is high sets the in-service bit whose index equals the chosen source's level. With nesting off, a vector read leaves the in-service register unchanged.
- R7: With nesting on, the chosen source has the most urgent (numerically smallest) level. A tie goes to the lowest source index. Source k takes its level from bits 4*(k%8)+2 : 4*(k%8) of the priority register at 0x20 + 4*(k/8).
- R8: With nesting on, a class line is high only if a pending enabled source has a level strictly smaller than the index of the lowest set in-service bit. When no in-service bit is set, any pending source qualifies.
- R9: A write of nonzero data to an in-service register clears only its lowest-indexed set bit, so 0x09 becomes 0x08 and then 0x00. A write of zero data has no effect, and a write to an all-zero register has no effect.
- R10: A vector read when no source qualifies returns the base with index 0 and leaves the in-service register unchanged.
- R11: The normal-class enable register (0x04) and the fast-class enable register (0x08) mask sources per class. A source that is not enabled for a class never raises that class's line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the strobe |
| src_req | input | NUM_SRC | Level-sensitive interrupt requests |
| irq_o | output | 1 | Normal-class request line |
| fiq_o | output | 1 | Fast-class request line |

## Verification
The hardest state to reach from the ports is an in-service register holding two levels with the more urgent one above the other, as in 0x09. A lower level can never be pushed while a more urgent one is in service. The stimulus therefore raises a level-3 source first and takes its vector. It then raises a level-0 source, which preempts it, and takes that vector as well. The bench next retires the levels one write at a time and checks the line after each step: sources still pending at the blocked level must stay masked until the most urgent bit is gone.

// File: rtl/nic_pkg.sv
package nic_pkg;
   // register byte offsets
   localparam int unsigned OFS_CTRL    = 'h00;
   localparam int unsigned OFS_EN_NRM  = 'h04;
   localparam int unsigned OFS_EN_FST  = 'h08;
   localparam int unsigned OFS_BASE    = 'h0C;
   localparam int unsigned OFS_VEC_NRM = 'h10;
   localparam int unsigned OFS_VEC_FST = 'h14;
   localparam int unsigned OFS_ISR_NRM = 'h18;
   localparam int unsigned OFS_ISR_FST = 'h1C;
   localparam int unsigned OFS_PRI     = 'h20;
   // priority fields per register and field pitch in bits
   localparam int unsigned PRI_PER_REG = 8;
   localparam int unsigned PRI_PITCH   = 4;
   // class numbering
   localparam int unsigned CLS_NRM = 0;
   localparam int unsigned CLS_FST = 1;
   localparam int unsigned NUM_CLS = 2;
endpackage

// File: rtl/nic_pick.sv
module nic_pick #(
   parameter int unsigned N     = 20,
   parameter int unsigned PRI_W = 3,
   parameter int unsigned IDX_W = 5
) (
   input  logic [N-1:0]            cand,
   input  logic [N-1:0][PRI_W-1:0] pri,
   output logic                    found,
   output logic [IDX_W-1:0]        idx,
   output logic [PRI_W-1:0]        lvl
);
   // most urgent level wins, ties resolved toward the lowest index
   always_comb begin
      found = 1'b0;
      idx   = '0;
      lvl   = '0;
      for (int i = 0; i < int'(N); i++) begin
         if (cand[i] && (!found || pri[i] < lvl)) begin
            found = 1'b1;
            idx   = IDX_W'(i);
            lvl   = pri[i];
         end
      end
   end
endmodule

// File: rtl/nic_isr.sv
module nic_isr #(
   parameter int unsigned LVL   = 8,
   parameter int unsigned PRI_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [PRI_W-1:0] push_lvl,
   input  logic             pop,
   output logic [LVL-1:0]   isr,
   output logic [PRI_W:0]   top_lvl
);
   logic [LVL-1:0] isr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         isr_q <= '0;
      else if (push)
         isr_q <= isr_q | (LVL'(1) << push_lvl);
      else if (pop)
         isr_q <= isr_q & (isr_q - LVL'(1));
   end

   // index of the most urgent in-service level, LVL when none
   always_comb begin
      top_lvl = (PRI_W+1)'(LVL);
      for (int i = int'(LVL) - 1; i >= 0; i--)
         if (isr_q[i]) top_lvl = (PRI_W+1)'(i);
   end

   assign isr = isr_q;
endmodule

// File: rtl/nic_class.sv
module nic_class #(
   parameter int unsigned N     = 20,
   parameter int unsigned LVL   = 8,
   parameter int unsigned PRI_W = 3,
   parameter int unsigned IDX_W = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    nest_en,
   input  logic [N-1:0]            pend,
   input  logic [N-1:0][PRI_W-1:0] pri,
   input  logic                    vec_rd,
   input  logic                    pop,
   output logic                    line,
   output logic [IDX_W-1:0]        win_idx,
   output logic [LVL-1:0]          isr
);
   logic [PRI_W:0]          top_lvl;
   logic [N-1:0]            elig;
   logic [N-1:0][PRI_W-1:0] pri_eff;
   logic [PRI_W-1:0]        win_lvl;
   logic                    found;

   always_comb begin
      for (int i = 0; i < int'(N); i++) begin
         elig[i]    = pend[i] && (!nest_en || ({1'b0, pri[i]} < top_lvl));
         pri_eff[i] = nest_en ? pri[i] : '0;
      end
   end

   nic_pick #(.N(N), .PRI_W(PRI_W), .IDX_W(IDX_W)) u_pick (
      .cand (elig),
      .pri  (pri_eff),
      .found(found),
      .idx  (win_idx),
      .lvl  (win_lvl)
   );

   nic_isr #(.LVL(LVL), .PRI_W(PRI_W)) u_isr (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (vec_rd && nest_en && found),
      .push_lvl(win_lvl),
      .pop     (pop),
      .isr     (isr),
      .top_lvl (top_lvl)
   );

   assign line = found;
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
   import nic_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 20,
   parameter int unsigned NUM_LVL     = 8,
   parameter int unsigned BASE_W      = 16,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter bit          FIQ_PREEMPT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] src_req,
   output logic               irq_o,
   output logic               fiq_o
);
   localparam int unsigned PRI_W   = $clog2(NUM_LVL);
   localparam int unsigned IDX_W   = $clog2(NUM_SRC);
   localparam int unsigned NUM_PRI = (NUM_SRC + PRI_PER_REG - 1) / PRI_PER_REG;
   localparam int unsigned VEC_W   = 2 + IDX_W + BASE_W;

   initial begin
      assert (DATA_W >= 32) else $error("DATA_W below 32");
      assert (VEC_W <= DATA_W) else $error("vector fields exceed DATA_W");
      assert (PRI_W + 1 <= PRI_PITCH) else $error("priority field too wide");
      assert (NUM_LVL == (1 << PRI_W)) else $error("NUM_LVL not a power of two");
      assert (NUM_SRC <= DATA_W && NUM_SRC >= 2) else $error("NUM_SRC out of range");
      assert (OFS_PRI + 4 * NUM_PRI <= (1 << ADDR_W)) else $error("ADDR_W too small");
   end

   logic wr_en, rd_en;
   assign wr_en = bus_sel && bus_wr;
   assign rd_en = bus_sel && !bus_wr;

   logic [1:0]                       ctrl_q;
   logic [BASE_W-1:0]                base_q;
   logic [NUM_CLS-1:0][NUM_SRC-1:0]  en_q;
   logic [NUM_SRC-1:0][PRI_W-1:0]    pri_q;
   logic [NUM_CLS-1:0]               line_w, vec_rd, pop;
   logic [NUM_CLS-1:0][IDX_W-1:0]    idx_w;
   logic [NUM_CLS-1:0][NUM_LVL-1:0]  isr_w;
   logic [NUM_CLS-1:0][DATA_W-1:0]   vec_w;
   logic [NUM_PRI-1:0][DATA_W-1:0]   pri_rd;
   logic [NUM_LVL-1:0]               isr_irq, isr_fiq;

   // control, base and enable registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         base_q <= '0;
         en_q   <= '0;
      end else if (wr_en) begin
         if (bus_addr == ADDR_W'(OFS_CTRL))   ctrl_q <= bus_wdata[1:0];
         if (bus_addr == ADDR_W'(OFS_BASE))   base_q <= bus_wdata[BASE_W-1:0];
         if (bus_addr == ADDR_W'(OFS_EN_NRM)) en_q[CLS_NRM] <= bus_wdata[NUM_SRC-1:0];
         if (bus_addr == ADDR_W'(OFS_EN_FST)) en_q[CLS_FST] <= bus_wdata[NUM_SRC-1:0];
      end
   end

   // per-source priority fields
   for (genvar k = 0; k < int'(NUM_SRC); k++) begin : g_pri
      localparam int unsigned REG_I = k / PRI_PER_REG;
      localparam int unsigned BIT_I = (k % PRI_PER_REG) * PRI_PITCH;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pri_q[k] <= '0;
         else if (wr_en && bus_addr == ADDR_W'(OFS_PRI + 4 * REG_I))
            pri_q[k] <= bus_wdata[BIT_I +: PRI_W];
      end
   end

   always_comb begin
      pri_rd = '0;
      for (int k = 0; k < int'(NUM_SRC); k++)
         pri_rd[k / PRI_PER_REG][(k % PRI_PER_REG) * PRI_PITCH +: PRI_W] = pri_q[k];
   end

   // two request classes, each with its own arbiter and in-service stack
   for (genvar c = 0; c < int'(NUM_CLS); c++) begin : g_cls
      localparam int unsigned VEC_OFS = (c == CLS_NRM) ? OFS_VEC_NRM : OFS_VEC_FST;
      localparam int unsigned ISR_OFS = (c == CLS_NRM) ? OFS_ISR_NRM : OFS_ISR_FST;

      assign vec_rd[c] = rd_en && bus_addr == ADDR_W'(VEC_OFS);
      assign pop[c]    = wr_en && bus_addr == ADDR_W'(ISR_OFS) && (bus_wdata != '0);

      nic_class #(.N(NUM_SRC), .LVL(NUM_LVL), .PRI_W(PRI_W), .IDX_W(IDX_W)) u_cls (
         .clk    (clk),
         .rst_n  (rst_n),
         .nest_en(ctrl_q[c]),
         .pend   (src_req & en_q[c]),
         .pri    (pri_q),
         .vec_rd (vec_rd[c]),
         .pop    (pop[c]),
         .line   (line_w[c]),
         .win_idx(idx_w[c]),
         .isr    (isr_w[c])
      );

      assign vec_w[c] = DATA_W'({base_q, idx_w[c], 2'b00});
   end

   assign isr_irq = isr_w[CLS_NRM];
   assign isr_fiq = isr_w[CLS_FST];

   // output lines: optional fast-over-normal precedence in flat mode
   if (FIQ_PREEMPT) begin : g_pre
      assign irq_o = line_w[CLS_NRM] && (ctrl_q[CLS_NRM] || !line_w[CLS_FST]);
   end else begin : g_nopre
      assign irq_o = line_w[CLS_NRM];
   end
   assign fiq_o = line_w[CLS_FST];

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_CTRL))    bus_rdata = DATA_W'(ctrl_q);
      if (bus_addr == ADDR_W'(OFS_EN_NRM))  bus_rdata = DATA_W'(en_q[CLS_NRM]);
      if (bus_addr == ADDR_W'(OFS_EN_FST))  bus_rdata = DATA_W'(en_q[CLS_FST]);
      if (bus_addr == ADDR_W'(OFS_BASE))    bus_rdata = DATA_W'(base_q);
      if (bus_addr == ADDR_W'(OFS_VEC_NRM)) bus_rdata = vec_w[CLS_NRM];
      if (bus_addr == ADDR_W'(OFS_VEC_FST)) bus_rdata = vec_w[CLS_FST];
      if (bus_addr == ADDR_W'(OFS_ISR_NRM)) bus_rdata = DATA_W'(isr_irq);
      if (bus_addr == ADDR_W'(OFS_ISR_FST)) bus_rdata = DATA_W'(isr_fiq);
      for (int r = 0; r < int'(NUM_PRI); r++)
         if (bus_addr == ADDR_W'(OFS_PRI + 4 * r)) bus_rdata = pri_rd[r];
   end
endmodule

// File: rtl/nic_chk.sv
module nic_chk
   import nic_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NUM_LVL = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_sel,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic [1:0]         ctrl,
   input logic [NUM_LVL-1:0] isr_irq,
   input logic               irq_o,
   input logic               fiq_o
);
   logic rd_vec, pop_nz, pop_any;
   assign rd_vec  = bus_sel && !bus_wr && bus_addr == ADDR_W'(OFS_VEC_NRM);
   assign pop_nz  = bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_ISR_NRM) && bus_wdata != '0;
   assign pop_any = bus_sel && bus_wr && bus_addr == ADDR_W'(OFS_ISR_NRM);

   // R9: a nonzero retire write removes exactly one in-service level
   a_r9_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_nz && isr_irq != '0) |=> ($countones(isr_irq) == $countones($past(isr_irq)) - 1));

   // R9: retiring an empty register leaves it empty
   a_r9_empty_stays: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_any && isr_irq == '0) |=> (isr_irq == '0));

   // R6: a vector read in nested mode with the line high records a level
   a_r6_push: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vec && ctrl[0] && irq_o) |=> (isr_irq != '0));

   // R6: no recording in flat mode
   a_r6_flat_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vec && !ctrl[0]) |=> $stable(isr_irq));

   // R4: fast line takes precedence in flat mode
   a_r4_fiq_first: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[0] && fiq_o) |-> !irq_o);

   // R8: level 0 in service masks every normal source
   a_r8_top_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[0] && isr_irq[0]) |-> !irq_o);

   // R5: reserved vector bits read as zero
   a_r5_vec_fmt: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vec |-> (bus_rdata[1:0] == 2'b00 && bus_rdata[31:23] == '0));
endmodule

bind nest_irq_ctrl nic_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LVL(NUM_LVL)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_sel  (bus_sel),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .ctrl     (ctrl_q),
   .isr_irq  (isr_irq),
   .irq_o    (irq_o),
   .fiq_o    (fiq_o)
);

// File: tb/tb_nest_irq_ctrl.sv
module tb_nest_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [19:0] src_req = '0;
   logic        irq_o, fiq_o;

   always #10 clk = ~clk;   // 50 MHz

   nest_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src_req(src_req), .irq_o(irq_o), .fiq_o(fiq_o)
   );

   typedef struct {
      logic [31:0] val;
      string       tag;
   } item_t;

   item_t       expq[$];
   logic [31:0] obsq[$];
   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 1'b0;
   logic [15:0] base = 16'h0;
   logic [31:0] pri_sh [3];

   function automatic logic [31:0] vexp(int idx);
      return (32'(base) << 7) | (32'(idx) << 2);
   endfunction

   // monitor: pairs observed results with expected items
   initial begin
      forever begin
         @(posedge clk);
         while (obsq.size() > 0 && expq.size() > 0) begin
            item_t       e;
            logic [31:0] o;
            e = expq.pop_front();
            o = obsq.pop_front();
            n_run++;
            if (o !== e.val) begin
               n_fail++;
               $display("FAIL %s: got 0x%08h expected 0x%08h", e.tag, o, e.val);
            end
         end
      end
   end

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      item_t it;
      it.val = e; it.tag = tag;
      expq.push_back(it);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #2;
      obsq.push_back(bus_rdata);
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic expect_lines(input logic ei, input logic ef, input string tag);
      item_t it;
      it.val = {30'b0, ei, ef}; it.tag = tag;
      expq.push_back(it);
      @(negedge clk);
      #2;
      obsq.push_back({30'b0, irq_o, fiq_o});
   endtask

   task automatic set_pri(input int src, input int lvl);
      pri_sh[src / 8][(src % 8) * 4 +: 4] = 4'(lvl);
      bus_write(8'(8'h20 + 4 * (src / 8)), pri_sh[src / 8]);
   endtask

   task automatic set_req(input logic [19:0] r);
      @(negedge clk);
      src_req = r;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 3; i++) pri_sh[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // reset state
      expect_rd(8'h00, 32'h0, "R1 ctrl reset");
      expect_rd(8'h18, 32'h0, "R2 normal isr reset");
      expect_rd(8'h1C, 32'h0, "R2 fast isr reset");
      expect_rd(8'h10, 32'h0, "R2 vector reset");
      expect_lines(1'b0, 1'b0, "R2 lines idle");

      // control register width
      bus_write(8'h00, 32'hFFFF_FFFF);
      expect_rd(8'h00, 32'h3, "R1 ctrl only two bits");
      bus_write(8'h00, 32'h0);

      // flat mode: lowest index wins, priorities ignored
      base = 16'h1234;
      bus_write(8'h0C, 32'(base));
      bus_write(8'h04, 32'h000F_FFFF);
      set_pri(5, 7);
      set_pri(12, 0);
      set_req(20'h0_1020);
      expect_lines(1'b1, 1'b0, "R3 flat normal line");
      expect_rd(8'h10, vexp(5), "R3 R5 flat vector lowest index");
      expect_rd(8'h18, 32'h0, "R6 no push in flat mode");

      // fast class precedence, timer 1 index 8
      bus_write(8'h08, 32'h0000_0100);
      set_req(20'h0_1120);
      expect_lines(1'b0, 1'b1, "R4 fast over normal");
      expect_rd(8'h14, vexp(8), "R5 fast vector index 01000");
      expect_rd(8'h14, 32'h0009_1A20, "R5 fast vector literal");

      // per-class enable
      bus_write(8'h08, 32'h0);
      bus_write(8'h04, 32'h0000_0001);
      set_req(20'h0_1120);
      expect_lines(1'b0, 1'b0, "R11 disabled sources silent");
      bus_write(8'h04, 32'h000F_FFFF);

      // nested normal class
      bus_write(8'h00, 32'h1);
      set_pri(3, 3);
      set_pri(7, 3);
      set_pri(10, 1);
      set_pri(15, 5);
      set_req(20'h0_8088);
      expect_lines(1'b1, 1'b0, "R8 line with empty stack");
      expect_rd(8'h10, vexp(3), "R7 tie goes to lower index");
      expect_rd(8'h18, 32'h08, "R6 level 3 recorded");
      expect_lines(1'b0, 1'b0, "R8 levels 3 and below masked");
      expect_rd(8'h10, vexp(0), "R10 empty vector is base");
      expect_rd(8'h18, 32'h08, "R10 stack unchanged");
      set_req(20'h0_8488);
      expect_lines(1'b1, 1'b0, "R8 more urgent source passes");
      expect_rd(8'h10, vexp(10), "R7 most urgent level wins");
      expect_rd(8'h18, 32'h0A, "R6 level 1 added");
      expect_lines(1'b0, 1'b0, "R8 level 1 masks itself");
      bus_write(8'h18, 32'hFF);
      expect_rd(8'h18, 32'h08, "R9 pop clears level 1 only");
      expect_lines(1'b1, 1'b0, "R8 level 1 unmasked again");
      set_req(20'h0_8088);
      bus_write(8'h18, 32'h0);
      expect_rd(8'h18, 32'h08, "R9 zero write ignored");
      bus_write(8'h18, 32'hFF);
      expect_rd(8'h18, 32'h00, "R9 stack emptied");
      expect_lines(1'b1, 1'b0, "R8 line back after unwind");
      bus_write(8'h18, 32'hFF);
      expect_rd(8'h18, 32'h00, "R9 pop on empty ignored");

      // build 0x09 then unwind
      set_pri(0, 0);
      set_req(20'h0_0008);
      expect_rd(8'h10, vexp(3), "R7 level 3 alone");
      set_req(20'h0_0009);
      expect_lines(1'b1, 1'b0, "R8 level 0 preempts");
      expect_rd(8'h10, vexp(0), "R7 level 0 vector");
      expect_rd(8'h18, 32'h09, "R6 stack 0x09");
      expect_lines(1'b0, 1'b0, "R8 level 0 masks all");
      bus_write(8'h18, 32'hFF);
      expect_rd(8'h18, 32'h08, "R9 0x09 to 0x08");
      bus_write(8'h18, 32'hFF);
      expect_rd(8'h18, 32'h00, "R9 0x08 to 0x00");

      // nested fast class uses its own stack
      bus_write(8'h00, 32'h2);
      bus_write(8'h04, 32'h0);
      bus_write(8'h08, 32'h0000_0100);
      set_pri(8, 2);
      set_req(20'h0_0100);
      expect_rd(8'h14, vexp(8), "R7 fast nested vector");
      expect_rd(8'h1C, 32'h04, "R6 fast level 2 recorded");
      expect_rd(8'h18, 32'h00, "R6 normal stack untouched");

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule